// File: doc/BRIEF.md
# Lock-Aware Two-Way Replacement Selector

This block keeps the replacement bookkeeping for a two-way set-associative cache: one least-recently-used bit per set and one lock bit per line. When the cache misses, it receives a set index and the valid bits of the two lines in that set. It answers with the way to refill and a flag that says whether a refill may happen at all. Tag comparison, data arrays and the memory bus are handled elsewhere.

An empty line that is not locked is preferred. Otherwise the older of the two lines is picked. A locked line is never picked. When both lines of a set are locked, the block refuses allocation. The cache reports each hit and each completed refill as a "touch", which marks the touched way as most recent. A separate command port sets or clears the lock of any single line.

Victim queries travel over a valid/ready request channel and a valid/ready response channel, with a one-entry response register between them. A new request is accepted when the response register is empty, or when it is being drained in the same cycle. While the consumer holds `rsp_ready` low, the pending response stays fixed and further requests are stalled. Touch and lock commands are plain single-cycle strobes and cannot be back-pressured.

Top module: `way_victim_sel`

## Requirements
- R1: After reset every LRU bit and every lock bit is 0 (way 0 is the LRU way of every set, and no line is locked), `rsp_valid` is 0 and `req_ready` is 1.
- R2: An unlocked way whose `req_lvalid` bit is 0 is chosen before any valid way. If both ways are invalid and unlocked, way 0 is chosen. `rsp_way` is 0 for way 0 and 1 for way 1, and `req_lvalid[w]` belongs to way w.
- R3: When both ways are valid and unlocked, `rsp_way` is the set's LRU way, and `rsp_alloc` is 1.
- R4: A locked way is never returned with `rsp_alloc`=1. If the LRU way or the only invalid way is locked and the other way is not, the other way is returned.
- R5: When both ways of the set are locked, `rsp_alloc` is 0 and `rsp_way` is 0.
- R6: A cycle with `touch_en`=1 sets the LRU way of `touch_set` to the way that was not touched (`~touch_way`). Other sets are unchanged.
- R7: A cycle with `lock_en`=1 writes `lock_val` (1 locks, 0 unlocks) into the lock bit of line (`lock_set`, `lock_way`) only. The other way of that set and all other sets are unaffected.
- R8: A request is accepted on a clock edge where `req_valid` and `req_ready` are both 1, with `req_ready` = !`rsp_valid` || `rsp_ready`. The response is valid from the next cycle. It stays unchanged while `rsp_valid`=1 and `rsp_ready`=0.
- R9: A response reflects the LRU and lock state as it was before any touch or lock command applied on the same accepting edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Victim query offered |
| req_ready | output | 1 | Query can be taken this cycle |
| req_set | input | IDX_W (7) | Set index of the query |
| req_lvalid | input | 2 | Line valid bits of the set, bit w for way w |
| rsp_valid | output | 1 | Victim answer present |
| rsp_ready | input | 1 | Consumer takes the answer |
| rsp_way | output | 1 | Way to refill |
| rsp_alloc | output | 1 | 1 when a refill is allowed |
| touch_en | input | 1 | Hit or completed refill strobe |
| touch_set | input | IDX_W (7) | Set that was used |
| touch_way | input | 1 | Way that was used |
| lock_en | input | 1 | Lock write strobe |
| lock_set | input | IDX_W (7) | Set of the line to lock or unlock |
| lock_way | input | 1 | Way of the line to lock or unlock |
| lock_val | input | 1 | 1 locks, 0 unlocks |

## Verification
A corrupted LRU bit only shows when that set is queried with both lines valid and unlocked: the very next response then names the wrong way. A dropped or misplaced lock write shows in the first query to that set in which the locked way would otherwise be picked. The answer then carries `rsp_alloc`=1 on a locked way, or on a way the bench expects to be refused. The tests therefore read the stored state back through the victim answer one cycle after each write, using valid-bit patterns that make the answer depend on the bit being probed.

// File: rtl/victim_pkg.sv
package victim_pkg;
  typedef logic [1:0] way_vec_t;

  typedef struct packed {
    logic alloc;
    logic way;
  } victim_t;
endpackage

// File: rtl/lru_store.sv
module lru_store #(
  parameter int SETS  = 128,
  parameter int IDX_W = $clog2(SETS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_set,
  input  logic             wr_way,
  input  logic [IDX_W-1:0] rd_set,
  output logic             rd_lru,
  output logic [SETS-1:0]  bits
);
  logic [SETS-1:0] lru_q;

  // The stored bit names the way that was used least recently.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lru_q <= '0;
    end else if (wr_en) begin
      lru_q[wr_set] <= ~wr_way;
    end
  end

  assign rd_lru = lru_q[rd_set];
  assign bits   = lru_q;
endmodule

// File: rtl/lock_store.sv
module lock_store
  import victim_pkg::*;
#(
  parameter int SETS  = 128,
  parameter int WAYS  = 2,
  parameter int IDX_W = $clog2(SETS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_set,
  input  logic             wr_way,
  input  logic             wr_val,
  input  logic [IDX_W-1:0] rd_set,
  output way_vec_t         rd_lock
);
  for (genvar w = 0; w < WAYS; w++) begin : g_way
    logic [SETS-1:0] lk_q;
    logic            sel;

    assign sel = wr_en && (int'(wr_way) == w);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        lk_q <= '0;
      end else if (sel) begin
        lk_q[wr_set] <= wr_val;
      end
    end

    assign rd_lock[w] = lk_q[rd_set];
  end
endmodule

// File: rtl/victim_pick.sv
module victim_pick
  import victim_pkg::*;
(
  input  way_vec_t lvalid,
  input  way_vec_t locked,
  input  logic     lru,
  output victim_t  pick
);
  way_vec_t usable;
  way_vec_t empty_ok;

  assign usable   = ~locked;
  assign empty_ok = usable & ~lvalid;

  always_comb begin
    pick = '{alloc: 1'b0, way: 1'b0};
    if (empty_ok[0]) begin
      pick = '{alloc: 1'b1, way: 1'b0};
    end else if (empty_ok[1]) begin
      pick = '{alloc: 1'b1, way: 1'b1};
    end else if (usable[lru]) begin
      pick = '{alloc: 1'b1, way: lru};
    end else if (usable[~lru]) begin
      pick = '{alloc: 1'b1, way: ~lru};
    end
  end
endmodule

// File: rtl/way_victim_sel.sv
module way_victim_sel
  import victim_pkg::*;
#(
  parameter int SETS  = 128,
  parameter int IDX_W = $clog2(SETS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [IDX_W-1:0] req_set,
  input  logic [1:0]       req_lvalid,
  output logic             rsp_valid,
  input  logic             rsp_ready,
  output logic             rsp_way,
  output logic             rsp_alloc,
  input  logic             touch_en,
  input  logic [IDX_W-1:0] touch_set,
  input  logic             touch_way,
  input  logic             lock_en,
  input  logic [IDX_W-1:0] lock_set,
  input  logic             lock_way,
  input  logic             lock_val
);
  logic            lru_rd;
  logic [SETS-1:0] lru_bits;
  way_vec_t        lk_rd;
  victim_t         pick;
  victim_t         rsp_q;
  logic            req_fire;

  lru_store #(.SETS(SETS), .IDX_W(IDX_W)) u_lru (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (touch_en),
    .wr_set (touch_set),
    .wr_way (touch_way),
    .rd_set (req_set),
    .rd_lru (lru_rd),
    .bits   (lru_bits)
  );

  lock_store #(.SETS(SETS), .WAYS(2), .IDX_W(IDX_W)) u_lock (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (lock_en),
    .wr_set  (lock_set),
    .wr_way  (lock_way),
    .wr_val  (lock_val),
    .rd_set  (req_set),
    .rd_lock (lk_rd)
  );

  victim_pick u_pick (
    .lvalid (req_lvalid),
    .locked (lk_rd),
    .lru    (lru_rd),
    .pick   (pick)
  );

  assign req_ready = !rsp_valid || rsp_ready;
  assign req_fire  = req_valid && req_ready;

  // One-entry response register; it holds its answer while the consumer stalls.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_q     <= '0;
    end else if (req_fire) begin
      rsp_valid <= 1'b1;
      rsp_q     <= pick;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

  assign rsp_way   = rsp_q.way;
  assign rsp_alloc = rsp_q.alloc;
endmodule

// File: rtl/way_victim_sel_chk.sv
module way_victim_sel_chk #(
  parameter int SETS  = 128,
  parameter int IDX_W = $clog2(SETS)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_fire,
  input logic [1:0]       req_lvalid,
  input logic [1:0]       lk_rd,
  input logic             req_ready,
  input logic             rsp_valid,
  input logic             rsp_ready,
  input logic             rsp_way,
  input logic             rsp_alloc,
  input logic             touch_en,
  input logic [IDX_W-1:0] touch_set,
  input logic             touch_way,
  input logic [SETS-1:0]  lru_bits
);
  logic [1:0] lk_cap;
  logic [1:0] vld_cap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lk_cap  <= '0;
      vld_cap <= '0;
    end else if (req_fire) begin
      lk_cap  <= lk_rd;
      vld_cap <= req_lvalid;
    end
  end

  // R4: an answer that allows refill never names a locked line
  a_r4_never_locked: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_alloc) |-> !lk_cap[rsp_way]);

  // R5: both lines locked refuses allocation
  a_r5_no_victim: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && lk_cap == 2'b11) |-> !rsp_alloc);

  // R2: an unlocked empty line exists, so the chosen line is empty
  a_r2_empty_first: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && ((~vld_cap & ~lk_cap) != 2'b00)) |-> (rsp_alloc && !vld_cap[rsp_way]));

  // R6: touching a way makes the other way least recent
  a_r6_touch_update: assert property (@(posedge clk) disable iff (!rst_n)
    touch_en |=> (lru_bits[$past(touch_set)] == !$past(touch_way)));

  // R8: a stalled answer holds still
  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_way) && $stable(rsp_alloc)));

  // R8: an accepted request yields an answer in the next cycle
  a_r8_resp_next: assert property (@(posedge clk) disable iff (!rst_n)
    req_fire |=> rsp_valid);

  // R8: ready follows the response register
  a_r8_ready: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready == (!rsp_valid || rsp_ready));
endmodule

bind way_victim_sel way_victim_sel_chk #(.SETS(SETS), .IDX_W(IDX_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_fire   (req_fire),
  .req_lvalid (req_lvalid),
  .lk_rd      (lk_rd),
  .req_ready  (req_ready),
  .rsp_valid  (rsp_valid),
  .rsp_ready  (rsp_ready),
  .rsp_way    (rsp_way),
  .rsp_alloc  (rsp_alloc),
  .touch_en   (touch_en),
  .touch_set  (touch_set),
  .touch_way  (touch_way),
  .lru_bits   (lru_bits)
);

// File: tb/way_victim_sel_tb.sv
`timescale 1ns/1ps
module way_victim_sel_tb;
  localparam int SETS  = 128;
  localparam int IDX_W = $clog2(SETS);

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             req_valid = 1'b0;
  logic             req_ready;
  logic [IDX_W-1:0] req_set = '0;
  logic [1:0]       req_lvalid = '0;
  logic             rsp_valid;
  logic             rsp_ready = 1'b1;
  logic             rsp_way;
  logic             rsp_alloc;
  logic             touch_en = 1'b0;
  logic [IDX_W-1:0] touch_set = '0;
  logic             touch_way = 1'b0;
  logic             lock_en = 1'b0;
  logic [IDX_W-1:0] lock_set = '0;
  logic             lock_way = 1'b0;
  logic             lock_val = 1'b0;

  int errors = 0;
  int checks = 0;

  always #2.5 clk = ~clk;

  way_victim_sel #(.SETS(SETS)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_set(req_set), .req_lvalid(req_lvalid),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_way(rsp_way), .rsp_alloc(rsp_alloc),
    .touch_en(touch_en), .touch_set(touch_set), .touch_way(touch_way),
    .lock_en(lock_en), .lock_set(lock_set), .lock_way(lock_way), .lock_val(lock_val)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Returns {rsp_valid, alloc, way} sampled one cycle after acceptance.
  task automatic query(input int set, input logic [1:0] vld, output logic [2:0] res);
    @(negedge clk);
    req_valid  = 1'b1;
    req_set    = IDX_W'(set);
    req_lvalid = vld;
    @(negedge clk);
    req_valid = 1'b0;
    res = {rsp_valid, rsp_alloc, rsp_way};
  endtask

  task automatic touch(input int set, input logic way);
    @(negedge clk);
    touch_en = 1'b1; touch_set = IDX_W'(set); touch_way = way;
    @(negedge clk);
    touch_en = 1'b0;
  endtask

  task automatic lock(input int set, input logic way, input logic val);
    @(negedge clk);
    lock_en = 1'b1; lock_set = IDX_W'(set); lock_way = way; lock_val = val;
    @(negedge clk);
    lock_en = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic t_reset();
    logic [2:0] r;
    chk("R1 rsp_valid after reset", 8'(rsp_valid), 8'h0);
    chk("R1 req_ready after reset", 8'(req_ready), 8'h1);
    query(5, 2'b11, r);
    chk("R1 lru zero: both valid picks way0", 8'(r), 8'b110);
  endtask

  task automatic t_invalid_first();
    logic [2:0] r;
    query(10, 2'b00, r);
    chk("R2 both invalid -> way0", 8'(r), 8'b110);
    query(10, 2'b01, r);
    chk("R2 way1 empty -> way1", 8'(r), 8'b111);
    touch(11, 1'b0);
    query(11, 2'b10, r);
    chk("R2 way0 empty beats lru=1", 8'(r), 8'b110);
  endtask

  task automatic t_lru();
    logic [2:0] r;
    touch(3, 1'b0);
    query(3, 2'b11, r);
    chk("R6 R3 touch way0 -> victim way1", 8'(r), 8'b111);
    touch(3, 1'b1);
    query(3, 2'b11, r);
    chk("R6 R3 touch way1 -> victim way0", 8'(r), 8'b110);
    query(4, 2'b11, r);
    chk("R6 other set untouched", 8'(r), 8'b110);
  endtask

  task automatic t_lock();
    logic [2:0] r;
    lock(7, 1'b0, 1'b1);
    query(7, 2'b11, r);
    chk("R4 lru way locked -> other way", 8'(r), 8'b111);
    query(7, 2'b10, r);
    chk("R4 empty way locked -> other way", 8'(r), 8'b111);
    query(8, 2'b11, r);
    chk("R7 lock limited to its set", 8'(r), 8'b110);
    lock(7, 1'b1, 1'b1);
    query(7, 2'b00, r);
    chk("R5 both locked -> no alloc", 8'(r), 8'b100);
    lock(7, 1'b0, 1'b0);
    query(7, 2'b11, r);
    chk("R7 unlock way0 only", 8'(r), 8'b110);
    query(7, 2'b01, r);
    chk("R4 way1 still locked though empty", 8'(r), 8'b110);
  endtask

  task automatic t_backpressure();
    @(negedge clk);
    rsp_ready  = 1'b0;
    req_valid  = 1'b1; req_set = IDX_W'(20); req_lvalid = 2'b00;
    @(negedge clk);
    chk("R8 first answer valid", 8'({rsp_valid, rsp_alloc, rsp_way}), 8'b110);
    chk("R8 ready low while stalled", 8'(req_ready), 8'h0);
    req_set = IDX_W'(21); req_lvalid = 2'b01;
    @(negedge clk);
    chk("R8 answer held under stall", 8'({rsp_valid, rsp_alloc, rsp_way}), 8'b110);
    rsp_ready = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R8 stalled request taken on drain", 8'({rsp_valid, rsp_alloc, rsp_way}), 8'b111);
    @(negedge clk);
    chk("R8 answer consumed", 8'(rsp_valid), 8'h0);
  endtask

  task automatic t_same_edge();
    logic [2:0] r;
    @(negedge clk);
    req_valid = 1'b1; req_set = IDX_W'(30); req_lvalid = 2'b11;
    touch_en  = 1'b1; touch_set = IDX_W'(30); touch_way = 1'b0;
    lock_en   = 1'b1; lock_set = IDX_W'(31); lock_way = 1'b0; lock_val = 1'b1;
    @(negedge clk);
    req_valid = 1'b0; touch_en = 1'b0; lock_en = 1'b0;
    chk("R9 answer uses lru before touch", 8'({rsp_valid, rsp_alloc, rsp_way}), 8'b110);
    query(30, 2'b11, r);
    chk("R9 touch visible afterwards", 8'(r), 8'b111);
  endtask

  task automatic t_reset_clears();
    logic [2:0] r;
    do_reset();
    query(7, 2'b11, r);
    chk("R1 locks cleared by reset", 8'(r), 8'b110);
    query(3, 2'b00, r);
    chk("R1 set 3 empty after reset -> way0", 8'(r), 8'b110);
    query(30, 2'b11, r);
    chk("R1 lru cleared by reset", 8'(r), 8'b110);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_invalid_first();
    t_lru();
    t_lock();
    t_backpressure();
    t_same_edge();
    t_reset_clears();
    repeat (2) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule